// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer with Free-Running Counter

A register-mapped timer unit for a system controller. It holds three reloadable down-counting channels: two of them 16 bits wide and one 32 bits wide. Alongside them sits a 40-bit up-counter that runs freely and never raises an interrupt. Every channel has the same control-bit layout whatever its width. A channel counts either the slow or the fast tick-enable input, as its control register selects. When it passes zero it flags an interrupt. It then either reloads from its load register (periodic mode) or wraps to its all-ones value (free-running mode).

A typical use divides the slow tick into a periodic system interrupt. Software writes the control register with enable clear, writes the load value (tick rate divided by the wanted rate, minus one), and then sets enable. The interrupt service routine acknowledges the interrupt by writing to the channel's clear register. It reads the 40-bit counter to measure elapsed fast ticks at a finer grain. Register access is a plain single-cycle bus: address, write data, write strobe, and combinational read data.

Top module: `ctr_bank`

## Requirements
- R1: After reset every register reads zero and all three interrupt outputs are low.
- R2: Each channel's control register is at channel base +0x08 (bases 0x00, 0x20 and 0x80). Bit 7 is enable, bit 6 selects periodic mode and bit 3 selects the fast tick. Only these three bits are stored, and they read back in the same positions. All other bits read zero.
- R3: A write to the load register (base +0x00) keeps the low W bits, where W is 16 for the first two channels and 32 for the third. In the same cycle, the write also replaces the current value (base +0x04). Both registers read back zero-extended.
- R4: While enabled, a channel decrements by one on each cycle that its selected tick is high. In periodic mode, a tick at value zero reloads the load value, so underflows occur every load+1 ticks.
- R5: In free-running mode (bit 6 clear), a tick at value zero wraps the channel to its all-ones value (0xFFFF or 0xFFFFFFFF).
- R6: With bit 3 set, only the fast tick decrements the channel; with bit 3 clear, only the slow tick does. The unselected tick has no effect.
- R7: A disabled channel holds its value. A control write that changes enable from 0 to 1 copies the load register into the current value.
- R8: An underflow sets the channel's interrupt output on the next clock edge. The output stays set until a write of any data to base +0x0C. If an underflow and a clear fall in the same cycle, the interrupt stays set.
- R9: Writes to a current-value register are ignored. Reads of the clear registers and of unmapped addresses return zero.
- R10: Bit 8 of the register at 0x64 enables the 40-bit counter. While enabled, it increments by one on each cycle with the fast tick high. It ignores the slow tick.
- R11: 0x60 reads counter bits 31:0. 0x64 reads counter bits 39:32 in bits 7:0 and the enable in bit 8. Writes to 0x60 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle high |
| tick_slow_i | input | 1 | Slow count-clock enable |
| tick_fast_i | input | 1 | Fast count-clock enable |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 3 | Pending interrupt per reloadable channel |

## Verification
The bench builds the block with its default parameters: narrow channels of 16 bits, a wide channel of 32 bits and a 40-bit free-running counter. Load writes act at once, so zero, underflow, reload and the all-ones wrap of both channel widths can be reached within a few ticks. The random phase therefore drives many underflows, enable edges and clear-versus-underflow collisions on all three channels. The carry out of the 40-bit counter's low word needs 2^32 ticks and stays out of reach. Its upper byte is checked only at zero.

// File: rtl/ctr_bank_pkg.sv
package ctr_bank_pkg;
  localparam int NUM_CH        = 3;
  localparam int ADDR_W        = 8;
  localparam int DATA_W        = 32;
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_PER_BIT  = 6;
  localparam int CTRL_FAST_BIT = 3;
  localparam int FREE_EN_BIT   = 8;

  localparam logic [ADDR_W-1:0] OFF_LOAD = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_VAL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h0C;
  localparam logic [ADDR_W-1:0] FREE_LO_ADDR = 8'h60;
  localparam logic [ADDR_W-1:0] FREE_HI_ADDR = 8'h64;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } chan_ctrl_t;

  function automatic logic [ADDR_W-1:0] chan_base(input int k);
    case (k)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction

  function automatic chan_ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
    chan_ctrl_t c;
    c.en       = w[CTRL_EN_BIT];
    c.periodic = w[CTRL_PER_BIT];
    c.fast     = w[CTRL_FAST_BIT];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_to_word(input chan_ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_EN_BIT]   = c.en;
    w[CTRL_PER_BIT]  = c.periodic;
    w[CTRL_FAST_BIT] = c.fast;
    return w;
  endfunction
endpackage

// File: rtl/ctr_chan.sv
module ctr_chan
  import ctr_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  input  logic              wr_load_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] val_o,
  output chan_ctrl_t        ctrl_o,
  output logic              irq_o,
  output logic              uf_o
);
  logic [W-1:0] load_q, val_q, val_d;
  chan_ctrl_t   ctrl_q, ctrl_wr;
  logic         irq_q, tick_sel, step, uf;
  logic         unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ctrl_wr  = ctrl_from_word(wdata_i);
  assign tick_sel = ctrl_q.fast ? tick_fast_i : tick_slow_i;
  assign step     = ctrl_q.en & tick_sel;
  assign uf       = step & (val_q == '0);

  // priority: load write, then enable-rise reload, then count
  always_comb begin
    val_d = val_q;
    if (wr_load_i)                             val_d = wdata_i[W-1:0];
    else if (wr_ctrl_i && ctrl_wr.en && !ctrl_q.en) val_d = load_q;
    else if (step) begin
      if (val_q == '0) val_d = ctrl_q.periodic ? load_q : '1;
      else             val_d = val_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      val_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_load_i) load_q <= wdata_i[W-1:0];
      if (wr_ctrl_i) ctrl_q <= ctrl_wr;
      val_q <= val_d;
      if (uf)            irq_q <= 1'b1;
      else if (wr_clr_i) irq_q <= 1'b0;
    end
  end

  assign load_o = DATA_W'(load_q);
  assign val_o  = DATA_W'(val_q);
  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;
  assign uf_o   = uf;
endmodule

// File: rtl/ctr_free.sv
module ctr_free #(
  parameter int W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic         en_bit_i,
  output logic [W-1:0] cnt_o,
  output logic         en_o
);
  logic [W-1:0] cnt_q;
  logic         en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (en_q && tick_i) cnt_q <= cnt_q + 1'b1;
      if (wr_en_i)        en_q  <= en_bit_i;
    end
  end

  assign cnt_o = cnt_q;
  assign en_o  = en_q;
endmodule

// File: rtl/ctr_rd_mux.sv
module ctr_rd_mux
  import ctr_bank_pkg::*;
#(
  parameter int FREE_W = 40
) (
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  load_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  val_i,
  input  chan_ctrl_t [NUM_CH-1:0]        ctrl_i,
  input  logic [FREE_W-1:0]              free_cnt_i,
  input  logic                           free_en_i,
  output logic [DATA_W-1:0]              rdata_o
);
  localparam int HI_W = FREE_W - DATA_W;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr_i == chan_base(k) + OFF_LOAD) rdata_o = load_i[k];
      if (addr_i == chan_base(k) + OFF_VAL)  rdata_o = val_i[k];
      if (addr_i == chan_base(k) + OFF_CTRL) rdata_o = ctrl_to_word(ctrl_i[k]);
    end
    if (addr_i == FREE_LO_ADDR) rdata_o = free_cnt_i[DATA_W-1:0];
    if (addr_i == FREE_HI_ADDR) begin
      rdata_o[HI_W-1:0]   = free_cnt_i[FREE_W-1:DATA_W];
      rdata_o[FREE_EN_BIT] = free_en_i;
    end
  end
endmodule

// File: rtl/ctr_bank.sv
module ctr_bank
  import ctr_bank_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] ch_load, ch_val;
  chan_ctrl_t [NUM_CH-1:0]       ch_ctrl;
  logic [NUM_CH-1:0]             ch_uf, ch_en;
  logic [FREE_W-1:0]             free_cnt;
  logic                          free_en;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int CW = (g == NUM_CH - 1) ? WIDE_W : NARROW_W;
    localparam logic [ADDR_W-1:0] BASE = chan_base(g);
    logic wr_load, wr_ctrl, wr_clr;

    assign wr_load = we_i && (addr_i == BASE + OFF_LOAD);
    assign wr_ctrl = we_i && (addr_i == BASE + OFF_CTRL);
    assign wr_clr  = we_i && (addr_i == BASE + OFF_CLR);

    ctr_chan #(.W(CW)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_slow_i (tick_slow_i),
      .tick_fast_i (tick_fast_i),
      .wr_load_i   (wr_load),
      .wr_ctrl_i   (wr_ctrl),
      .wr_clr_i    (wr_clr),
      .wdata_i     (wdata_i),
      .load_o      (ch_load[g]),
      .val_o       (ch_val[g]),
      .ctrl_o      (ch_ctrl[g]),
      .irq_o       (irq_o[g]),
      .uf_o        (ch_uf[g])
    );
    assign ch_en[g] = ch_ctrl[g].en;
  end

  ctr_free #(.W(FREE_W)) u_free (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_fast_i),
    .wr_en_i  (we_i && (addr_i == FREE_HI_ADDR)),
    .en_bit_i (wdata_i[FREE_EN_BIT]),
    .cnt_o    (free_cnt),
    .en_o     (free_en)
  );

  ctr_rd_mux #(.FREE_W(FREE_W)) u_rd (
    .addr_i     (addr_i),
    .load_i     (ch_load),
    .val_i      (ch_val),
    .ctrl_i     (ch_ctrl),
    .free_cnt_i (free_cnt),
    .free_en_i  (free_en),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/ctr_bank_chk.sv
module ctr_bank_chk
  import ctr_bank_pkg::*;
#(
  parameter int FREE_W = 40
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          we_i,
  input logic                          tick_fast_i,
  input logic [NUM_CH-1:0]             irq_o,
  input logic [NUM_CH-1:0]             ch_uf,
  input logic [NUM_CH-1:0]             ch_en,
  input logic [NUM_CH-1:0][DATA_W-1:0] ch_val,
  input logic [FREE_W-1:0]             free_cnt,
  input logic                          free_en
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_k
    assert_uf_sets_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_uf[k] |=> irq_o[k]);
    assert_irq_needs_uf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[k]) |-> $past(ch_uf[k]));
    assert_hold_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ch_en[k] && !we_i) |=> $stable(ch_val[k]));
  end

  assert_free_inc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_en && tick_fast_i) |=> (free_cnt == $past(free_cnt) + 1'b1));
  assert_free_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_fast_i |=> $stable(free_cnt));
endmodule

bind ctr_bank ctr_bank_chk #(.FREE_W(FREE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .tick_fast_i (tick_fast_i),
  .irq_o       (irq_o),
  .ch_uf       (ch_uf),
  .ch_en       (ch_en),
  .ch_val      (ch_val),
  .free_cnt    (free_cnt),
  .free_en     (free_en)
);

// File: tb/sim_ctr_bank.sv
module sim_ctr_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, ts = 1'b0, tf = 1'b0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  always #5 clk = ~clk;

  ctr_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .tick_slow_i(ts), .tick_fast_i(tf), .rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;

  logic [31:0] m_load [3];
  logic [31:0] m_val  [3];
  logic        m_en [3], m_per [3], m_fast [3], m_irq [3];
  logic [39:0] m_fcnt;
  logic        m_fen;

  logic [7:0] alist [15] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h20, 8'h24, 8'h28, 8'h2C,
                            8'h80, 8'h84, 8'h88, 8'h8C, 8'h60, 8'h64, 8'h40};

  function automatic logic [7:0] bbase(int k);
    return (k == 0) ? 8'h00 : ((k == 1) ? 8'h20 : 8'h80);
  endfunction

  function automatic logic [31:0] bmask(int k);
    return (k == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 3; k++) begin
      if (a == bbase(k))         r = m_load[k];
      if (a == bbase(k) + 8'h04) r = m_val[k];
      if (a == bbase(k) + 8'h08) r = {24'd0, m_en[k], m_per[k], 2'b00, m_fast[k], 3'b000};
    end
    if (a == 8'h60) r = m_fcnt[31:0];
    if (a == 8'h64) r = {23'd0, m_fen, m_fcnt[39:32]};
    return r;
  endfunction

  task automatic model_step(input logic w, input logic [7:0] a, input logic [31:0] d,
                            input logic s, input logic f);
    for (int k = 0; k < 3; k++) begin
      logic sel, uf;
      logic [31:0] nv;
      sel = m_fast[k] ? f : s;
      uf  = m_en[k] && sel && (m_val[k] == 0);
      nv  = m_val[k];
      if (m_en[k] && sel)
        nv = (m_val[k] == 0) ? (m_per[k] ? m_load[k] : bmask(k)) : m_val[k] - 1;
      if (w && a == bbase(k) + 8'h08) begin
        if (d[7] && !m_en[k]) nv = m_load[k];
        m_en[k] = d[7]; m_per[k] = d[6]; m_fast[k] = d[3];
      end
      if (w && a == bbase(k)) begin
        m_load[k] = d & bmask(k);
        nv = d & bmask(k);
      end
      if (uf) m_irq[k] = 1'b1;
      else if (w && a == bbase(k) + 8'h0C) m_irq[k] = 1'b0;
      m_val[k] = nv;
    end
    if (m_fen && f) m_fcnt = m_fcnt + 1;
    if (w && a == 8'h64) m_fen = d[8];
  endtask

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic s, input logic f);
    we = w; addr = a; wdata = d; ts = s; tf = f;
    @(posedge clk);
    model_step(w, a, d, s, f);
    @(negedge clk);
    we = 1'b0; ts = 1'b0; tf = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic tick_s(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'd0, 1'b1, 1'b0);
  endtask

  task automatic tick_f(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'd0, 1'b0, 1'b1);
  endtask

  task automatic chk_rd(input logic [7:0] a, input string tag);
    logic [31:0] e;
    logic [2:0]  ei;
    addr = a; we = 1'b0;
    #1;
    e  = exp_rd(a);
    ei = {m_irq[2], m_irq[1], m_irq[0]};
    n_chk++;
    if (rdata !== e || irq !== ei) begin
      n_bad++;
      $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp=%b", tag, a, rdata, e, irq, ei);
    end
  endtask

  task automatic chk_lit(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic lit_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a; we = 1'b0;
    #1;
    chk_lit(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd97531);
    for (int k = 0; k < 3; k++) begin
      m_load[k] = '0; m_val[k] = '0; m_en[k] = 0; m_per[k] = 0; m_fast[k] = 0; m_irq[k] = 0;
    end
    m_fcnt = '0; m_fen = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 15; i++) chk_rd(alist[i], "R1 reset");

    // R2 control layout
    wr(8'h08, 32'hFFFF_FF48);
    lit_rd(8'h08, 32'h48, "R2 ctrl bits");
    wr(8'h08, 32'h0);

    // R3 load width and immediate value update
    wr(8'h00, 32'hABCD_1234);
    lit_rd(8'h00, 32'h1234, "R3 narrow load");
    lit_rd(8'h04, 32'h1234, "R3 narrow value");
    wr(8'h80, 32'hABCD_1234);
    lit_rd(8'h84, 32'hABCD_1234, "R3 wide value");

    // R4 periodic count: period load+1
    wr(8'h00, 32'd3);
    wr(8'h08, 32'hC0);
    tick_s(3);
    lit_rd(8'h04, 32'd0, "R4 at zero");
    chk_lit("R8 no irq yet", {31'd0, irq[0]}, 32'd0);
    tick_s(1);
    lit_rd(8'h04, 32'd3, "R4 reload");
    chk_lit("R8 irq set", {31'd0, irq[0]}, 32'd1);

    // R8 clear with arbitrary data, then collision
    wr(8'h0C, 32'hDEAD_BEEF);
    chk_lit("R8 cleared", {31'd0, irq[0]}, 32'd0);
    tick_s(3);
    cyc(1'b1, 8'h0C, 32'd0, 1'b1, 1'b0);
    #1;
    chk_lit("R8 set beats clear", {31'd0, irq[0]}, 32'd1);
    lit_rd(8'h04, 32'd3, "R4 reload after collision");
    wr(8'h0C, 32'd0);
    wr(8'h08, 32'h40);

    // R5 free-running wrap, wide channel
    wr(8'h80, 32'd1);
    wr(8'h88, 32'h80);
    tick_s(2);
    lit_rd(8'h84, 32'hFFFF_FFFF, "R5 wide wrap");
    chk_lit("R8 wide irq", {31'd0, irq[2]}, 32'd1);
    wr(8'h88, 32'd0);
    wr(8'h8C, 32'd0);

    // R6 tick select on narrow channel 1
    wr(8'h20, 32'd2);
    wr(8'h28, 32'h88);
    tick_s(4);
    lit_rd(8'h24, 32'd2, "R6 slow ignored");
    tick_f(3);
    lit_rd(8'h24, 32'h0000_FFFF, "R5 R6 narrow wrap on fast");
    wr(8'h28, 32'd0);
    wr(8'h2C, 32'd0);

    // R7 hold while disabled, reload on enable rise
    tick_s(5);
    lit_rd(8'h04, 32'd3, "R7 hold");
    wr(8'h08, 32'hC0);
    tick_s(2);
    lit_rd(8'h04, 32'd1, "R4 counting");
    wr(8'h08, 32'h40);
    tick_s(2);
    lit_rd(8'h04, 32'd1, "R7 hold mid-count");
    wr(8'h08, 32'hC0);
    lit_rd(8'h04, 32'd3, "R7 enable reload");
    wr(8'h08, 32'h40);

    // R9 value register read-only; unmapped reads zero
    wr(8'h04, 32'h5555);
    lit_rd(8'h04, 32'd3, "R9 value write ignored");
    lit_rd(8'h40, 32'd0, "R9 unmapped");
    lit_rd(8'h0C, 32'd0, "R9 clear reads zero");

    // R10 / R11 free counter
    tick_f(3);
    lit_rd(8'h60, 32'd0, "R10 disabled");
    wr(8'h64, 32'h100);
    lit_rd(8'h64, 32'h100, "R11 hi layout");
    tick_f(5);
    lit_rd(8'h60, 32'd5, "R10 counts fast");
    tick_s(3);
    lit_rd(8'h60, 32'd5, "R10 slow ignored");
    wr(8'h60, 32'hFFFF_FFFF);
    lit_rd(8'h60, 32'd5, "R11 low write ignored");
    wr(8'h64, 32'd0);
    tick_f(2);
    lit_rd(8'h60, 32'd5, "R10 stopped");

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      logic        w;
      logic [7:0]  a;
      logic [31:0] d;
      w = ($urandom % 10) < 3;
      a = alist[$urandom % 15];
      d = $urandom;
      if (a == 8'h00 || a == 8'h20 || a == 8'h80) d = d & 32'h1F;
      cyc(w, a, d, 1'($urandom % 2), 1'($urandom % 2));
      chk_rd(alist[$urandom % 15], "R4 R7 R8 R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule